// File: doc/BRIEF.md
# Memory Controller Mode and Chip-Select Gate

This block keeps the top-level mode register of an external memory controller and uses it to route or refuse each memory request. Three mode bits are kept: enable, boot address mirroring and low-power. A register port writes and reads them. A request port carries a valid strobe and an address. The top four address bits pick a chip-select window.

One cycle after a request, the block answers in one of two ways. It can accept the request and drive a one-hot static chip select. It can instead raise an error. Requests are refused while the controller is disabled or in low-power mode. The register port works in every mode.

While mirroring is on, as it is after reset, windows 0 and 4 are routed to chip select 1. This lets the boot device appear at the reset address. A refresh-enable output follows the enable bit, so dynamic memory keeps being refreshed in low-power mode. An idle flag tells software when it is safe to change the mode.

Top module: `memctl_mode_gate`

## Requirements
- R1: After reset the register reads 0x3 (enable=1, mirror=1, low-power=0), refresh_en is 1, idle is 1, and no response or chip select is driven.
- R2: A register write stores write-data bits [2:0] as bit 0 enable, bit 1 mirror and bit 2 low-power. Read data bits [31:3] are always 0, and writes to those bits have no effect.
- R3: Every request is answered in the cycle after its valid strobe. The answer is exactly one of accept or error. Nothing is answered in a cycle that follows no request.
- R4: With the controller enabled, not in low-power mode and mirror clear, address bits [31:28] equal to n (0..7) give accept with only chip-select bit n set.
- R5: A window value of 8..15 gives an error with all chip selects low.
- R6: With mirror set, windows 0 and 4 drive only chip-select bit 1. Windows 1, 2, 3, 5, 6 and 7 are routed as in R4.
- R7: While enable is 0 or low-power is 1, every request gives an error with all chip selects low.
- R8: Register writes and reads take effect normally while the controller is disabled or in low-power mode.
- R9: refresh_en equals the stored enable bit, whatever the low-power bit is. It changes in the cycle after the write.
- R10: idle is 1 only when no request is presented and no answer is being driven.
- R11: A request in the same cycle as a register write is judged by the mode in effect before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (always valid) |
| req_valid | input | 1 | Memory request valid |
| req_addr | input | 32 | Memory request address |
| rsp_accept | output | 1 | Request accepted |
| rsp_error | output | 1 | Request refused |
| rsp_cs | output | 8 | One-hot static chip select, valid with rsp_accept |
| refresh_en | output | 1 | Refresh enable for the refresh timer |
| idle | output | 1 | No request pending |

## Verification
A wrong mode bit shows up on the first request or register read after it goes wrong. It does not stay hidden: a stuck mirror bit sends window 0 or 4 to the wrong chip select, and a stuck enable or low-power bit flips accept to error. A lost enable bit also shows on refresh_en at once. Because every response is registered exactly once, a fault in the response stage appears one cycle after the request that exposes it. A reference model that is compared every clock catches it in that same cycle.

// File: rtl/memctl_mode_gate.sv
module memctl_mode_gate #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int NUM_CS     = 8,
  parameter int WIN_BITS   = 4,
  parameter int MIRROR_SRC = 1,
  parameter int MIRROR_A   = 0,
  parameter int MIRROR_B   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_accept,
  output logic              rsp_error,
  output logic [NUM_CS-1:0] rsp_cs,
  output logic              refresh_en,
  output logic              idle
);
  localparam int WIN_LSB = ADDR_W - WIN_BITS;
  localparam int MODE_W  = 3;

  logic [MODE_W-1:0] mode_q;
  wire mode_en  = mode_q[0];
  wire mode_mir = mode_q[1];
  wire mode_lpm = mode_q[2];

  wire [WIN_BITS-1:0] win = req_addr[ADDR_W-1:WIN_LSB];
  wire win_ok     = int'(win) < NUM_CS;
  wire mirror_hit = mode_mir && (int'(win) == MIRROR_A || int'(win) == MIRROR_B);
  wire gate_open  = mode_en & ~mode_lpm;
  wire take       = req_valid & gate_open & win_ok;

  logic [NUM_CS-1:0] cs_dec;
  always_comb begin
    cs_dec = '0;
    if (mirror_hit) cs_dec[MIRROR_SRC] = 1'b1;
    else
      for (int i = 0; i < NUM_CS; i++)
        if (int'(win) == i) cs_dec[i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= 3'b011;
      rsp_accept <= 1'b0;
      rsp_error  <= 1'b0;
      rsp_cs     <= '0;
    end else begin
      rsp_accept <= take;
      rsp_error  <= req_valid & ~(gate_open & win_ok);
      rsp_cs     <= take ? cs_dec : '0;
      if (reg_wen) mode_q <= reg_wdata[MODE_W-1:0];
    end
  end

  assign reg_rdata  = {{(DATA_W-MODE_W){1'b0}}, mode_q};
  assign refresh_en = mode_en;
  assign idle       = ~req_valid & ~rsp_accept & ~rsp_error;

  wire unused_bits = ^{reg_wdata[DATA_W-1:MODE_W], req_addr[WIN_LSB-1:0]};

  // R3
  rsp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_accept && rsp_error));
  // R3
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_accept || rsp_error));
  // R3
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(rsp_accept || rsp_error));
  // R4
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_accept |-> $countones(rsp_cs) == 1);
  // R5
  err_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_accept |-> rsp_cs == '0);
  // R7
  gated_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (!mode_en || mode_lpm)) |=> rsp_error);
  // R6
  mirror_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && gate_open && mirror_hit) |=> rsp_cs[MIRROR_SRC]);
  // R9
  refresh_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wen |=> refresh_en == $past(reg_wdata[0]));
endmodule

// File: tb/test_memctl_mode_gate.sv
module test_memctl_mode_gate;
  logic clk = 0, rst_n = 0;
  logic reg_wen = 0, req_valid = 0;
  logic [31:0] reg_wdata = 0, req_addr = 0, reg_rdata;
  logic rsp_accept, rsp_error, refresh_en, idle;
  logic [7:0] rsp_cs;
  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  memctl_mode_gate i_memctl_mode_gate (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_accept(rsp_accept), .rsp_error(rsp_error), .rsp_cs(rsp_cs),
    .refresh_en(refresh_en), .idle(idle));

  // behavioural reference
  int m_en, m_mir, m_lpm, m_acc, m_err, m_cs, m_win, m_tgt;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 1; m_mir = 1; m_lpm = 0; m_acc = 0; m_err = 0; m_cs = 0;
    end else begin
      m_acc = 0; m_err = 0; m_cs = 0;
      m_win = int'(req_addr >> 28);
      if (req_valid) begin
        if (m_en == 0 || m_lpm == 1 || m_win > 7) m_err = 1;
        else begin
          m_acc = 1;
          m_tgt = (m_mir == 1 && (m_win == 0 || m_win == 4)) ? 1 : m_win;
          m_cs = 1 << m_tgt;
        end
      end
      if (reg_wen) begin
        m_en = int'(reg_wdata[0]); m_mir = int'(reg_wdata[1]); m_lpm = int'(reg_wdata[2]);
      end
    end
  end

  task automatic chk(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R2 rdata vs model", reg_rdata, m_en + 2*m_mir + 4*m_lpm);
    chk("R3 accept vs model", rsp_accept, m_acc);
    chk("R3 error vs model", rsp_error, m_err);
    chk("R4 cs vs model", rsp_cs, m_cs);
    chk("R9 refresh vs model", refresh_en, m_en);
    chk("R10 idle vs model", idle, (!req_valid && m_acc == 0 && m_err == 0) ? 1 : 0);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL R3 watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(logic [31:0] d);
    @(posedge clk); #2 reg_wen = 1; reg_wdata = d;
    @(posedge clk); #2 reg_wen = 0;
  endtask

  // issue one request, then check the answer at the following negedge
  task automatic rq(logic [3:0] w, string tag, bit exp_acc, logic [7:0] exp_cs);
    @(posedge clk); #2 req_valid = 1; req_addr = {w, 28'h0123456};
    @(negedge clk); chk({tag, " idle low with request"}, idle, 0);
    @(posedge clk); #2 req_valid = 0;
    @(negedge clk);
    chk({tag, " accept"}, rsp_accept, exp_acc);
    chk({tag, " error"}, rsp_error, !exp_acc);
    chk({tag, " cs"}, rsp_cs, exp_cs);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", reg_rdata, 32'h3);
    chk("R1 refresh", refresh_en, 1);
    chk("R1 idle", idle, 1);
    chk("R1 no response", {rsp_accept, rsp_error, rsp_cs}, 0);

    // R6 mirror on after reset
    rq(4'd0, "R6 win0 mirrored", 1, 8'h02);
    rq(4'd4, "R6 win4 mirrored", 1, 8'h02);
    rq(4'd3, "R6 win3 direct", 1, 8'h08);
    rq(4'd9, "R5 win9", 0, 8'h00);

    // R4 / R5 all windows, mirror cleared
    wr(32'h1);
    for (int w = 0; w < 16; w++)
      rq(4'(w), (w < 8) ? "R4 window" : "R5 window", w < 8, (w < 8) ? 8'(1 << w) : 8'h0);

    // R2 reserved bits ignored
    wr(32'hFFFF_FFF9);
    @(negedge clk); chk("R2 reserved write ignored", reg_rdata, 32'h1);

    // R7 low-power: error, refresh kept
    wr(32'h5);
    @(negedge clk); chk("R9 refresh in low-power", refresh_en, 1);
    rq(4'd2, "R7 low-power", 0, 8'h00);
    wr(32'h7);
    @(negedge clk); chk("R8 write in low-power", reg_rdata, 32'h7);

    // R7 disabled: error, refresh off
    wr(32'h0);
    @(negedge clk); chk("R9 refresh off when disabled", refresh_en, 0);
    rq(4'd1, "R7 disabled", 0, 8'h00);
    wr(32'h2);
    @(negedge clk); chk("R8 write while disabled", reg_rdata, 32'h2);

    // R11 request with same-cycle write uses the old mode
    wr(32'h1);
    @(posedge clk); #2 req_valid = 1; req_addr = 32'h2000_0000; reg_wen = 1; reg_wdata = 32'h0;
    @(posedge clk); #2 req_valid = 0; reg_wen = 0;
    @(negedge clk);
    chk("R11 accept old mode", rsp_accept, 1);
    chk("R11 cs old mode", rsp_cs, 8'h04);
    chk("R11 new mode stored", reg_rdata, 32'h0);

    // R3 / R10 back-to-back requests
    wr(32'h1);
    @(posedge clk); #2 req_valid = 1; req_addr = 32'h5000_0000;
    @(posedge clk); #2 req_addr = 32'hA000_0000;
    @(negedge clk); chk("R3 first of pair", rsp_cs, 8'h20);
    @(posedge clk); #2 req_valid = 0;
    @(negedge clk); chk("R3 second of pair error", rsp_error, 1);
    chk("R10 idle low while answering", idle, 0);
    @(posedge clk); @(negedge clk); chk("R10 idle back high", idle, 1);

    repeat (2) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule